// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the write-side command front end of a word-wide parallel NOR flash behavioural model. Each host write arrives as a one-cycle strobe carrying an address and a 16-bit data word. The sequencer follows the multi-cycle unlock patterns and recognises four operations: word program, sector erase, block erase and whole-array erase. When a sequence completes, it latches the target address and data and holds a busy flag for a fixed number of clock cycles. During that time it updates a small internal storage array, and it discards every write strobe it receives.

The storage array is reduced so that it fits in block RAM. For each 2K-word sector it keeps a few word slots, chosen by the lowest address bits. Addresses that share the same sector and the same low bits refer to the same slot. A registered read port returns the stored contents, so the effect of each operation can be observed. Status-bit read-back during busy is handled by a separate block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset, `busy` is 0 and the sequencer waits for the first unlock cycle.
- R2: The unlock cycles are address 0x05555 with command byte 0xAA, then address 0x02AAA with byte 0x55. The full 19-bit address is compared, and so are only data bits 7:0. Data bits 15:8 of a command cycle have no effect.
- R3: A word program is the unlock pair, then 0x05555/0xA0, then one more write of any address and data. That fourth write starts the program.
- R4: A program can only clear bits. The addressed slot becomes its previous value ANDed with the written data.
- R5: An erase sequence is the unlock pair, 0x05555/0x80, the unlock pair again, and a sixth write. A sixth byte of 0x30 at any address sets to 0xFFFF every slot whose sector index (address bits 18:11) matches.
- R6: A sixth byte of 0x50 sets to 0xFFFF every slot whose block index (address bits 18:15) matches.
- R7: A sixth byte of 0x10 erases the whole array only when its address is 0x05555. At any other address it starts nothing.
- R8: A write that does not match the expected step returns the sequencer to idle. That write does not count as a first unlock cycle, and nothing starts.
- R9: `busy` rises on the second clock edge after the final write. It stays high for exactly PROG_CYC cycles after a program and ERASE_CYC cycles after an erase.
- R10: A write strobe is ignored if it arrives in the cycle right after a final write or while `busy` is high. The first write after `busy` falls is accepted.
- R11: `rd_data` is registered and appears one cycle after `rd_addr`. The slot it reads is {address bits 18:11, address bits 1:0}, and address bits 10:2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 19 | Word address of the write |
| wr_data | input | 16 | Data or command word of the write |
| rd_addr | input | 19 | Read word address |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | Internal program or erase in progress |

## Verification
The collision that matters is a host write landing in the same cycle as the start or end of an internal operation. This covers the hand-off cycle between the final write and the rise of `busy`, the cycle in which `busy` falls, and the first write after it. The bench drives unbroken back-to-back command streams, so writes fall on the hand-off cycle and on every busy cycle. It also starts a new sequence in the very cycle `busy` is seen low. A behavioural model predicts `busy` and every settled read on every clock, so a blocked write that slips through appears as a wrong busy span or a wrong stored word.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_C1   = 3'd1,
    S_C2   = 3'd2,
    S_PRG  = 3'd3,
    S_E3   = 3'd4,
    S_E4   = 3'd5,
    S_E5   = 3'd6
  } seq_st_e;

  localparam logic [15:0] UNLK_A1 = 16'h5555;
  localparam logic [15:0] UNLK_A2 = 16'h2AAA;
  localparam logic [7:0]  K_AA    = 8'hAA;
  localparam logic [7:0]  K_55    = 8'h55;
  localparam logic [7:0]  K_PRG   = 8'hA0;
  localparam logic [7:0]  K_ERS   = 8'h80;
  localparam logic [7:0]  K_SECT  = 8'h30;
  localparam logic [7:0]  K_BLK   = 8'h50;
  localparam logic [7:0]  K_CHIP  = 8'h10;

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy_i,
  output logic          start_o,
  output flash_op_e     op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  seq_st_e   st_q, st_d;
  flash_op_e op_q, op_d;
  logic      start_q, fire;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic       take, hit1, hit2;
  logic [7:0] cd;

  assign take = wr_en & ~busy_i & ~start_q;
  assign hit1 = (wr_addr == AW'(UNLK_A1));
  assign hit2 = (wr_addr == AW'(UNLK_A2));
  assign cd   = wr_data[7:0];

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    op_d = OP_PROG;
    if (take) begin
      unique case (st_q)
        S_IDLE: st_d = (hit1 && cd == K_AA) ? S_C1 : S_IDLE;
        S_C1:   st_d = (hit2 && cd == K_55) ? S_C2 : S_IDLE;
        S_C2: begin
          if (hit1 && cd == K_PRG)      st_d = S_PRG;
          else if (hit1 && cd == K_ERS) st_d = S_E3;
          else                          st_d = S_IDLE;
        end
        S_PRG: begin
          st_d = S_IDLE;
          fire = 1'b1;
          op_d = OP_PROG;
        end
        S_E3: st_d = (hit1 && cd == K_AA) ? S_E4 : S_IDLE;
        S_E4: st_d = (hit2 && cd == K_55) ? S_E5 : S_IDLE;
        S_E5: begin
          st_d = S_IDLE;
          if (cd == K_SECT) begin
            fire = 1'b1;
            op_d = OP_SECT;
          end else if (cd == K_BLK) begin
            fire = 1'b1;
            op_d = OP_BLK;
          end else if (cd == K_CHIP && hit1) begin
            fire = 1'b1;
            op_d = OP_CHIP;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      start_q <= 1'b0;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= fire;
      if (fire) begin
        op_q   <= op_d;
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign start_o = start_q;
  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R10
  no_start_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !start_q);

  // R3
  prog_after_a0_chk: assert property (@(posedge clk) disable iff (rst)
    (start_q && op_q == OP_PROG) |-> ($past(st_q) == S_PRG));

  // R7
  chip_at_5555_chk: assert property (@(posedge clk) disable iff (rst)
    (start_q && op_q == OP_CHIP) |-> (addr_q == AW'(UNLK_A1)));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 16,
  parameter int SECT_LSB  = 11,
  parameter int BLK_LSB   = 15,
  parameter int KEEP_LO   = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 1100,
  localparam int SECT_W   = AW - SECT_LSB,
  localparam int BLK_W    = AW - BLK_LSB,
  localparam int MEM_AW   = SECT_W + KEEP_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  flash_op_e         op_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [DW-1:0]     a_rdata,
  output logic              busy_o,
  output logic [MEM_AW-1:0] a_addr,
  output logic              a_we,
  output logic [DW-1:0]     a_wdata
);

  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic              busy_q, sweep_q, prog_wr_q, region_hit;
  logic [CNT_W-1:0]  cnt_q;
  logic [MEM_AW-1:0] ptr_q, tgt_idx;
  logic              unused_mid_bits;

  assign tgt_idx         = {addr_i[AW-1:SECT_LSB], addr_i[KEEP_LO-1:0]};
  assign unused_mid_bits = ^addr_i[SECT_LSB-1:KEEP_LO];

  always_comb begin
    unique case (op_i)
      OP_SECT: region_hit = (ptr_q[MEM_AW-1:KEEP_LO] == addr_i[AW-1:SECT_LSB]);
      OP_BLK:  region_hit = (ptr_q[MEM_AW-1 -: BLK_W] == addr_i[AW-1:BLK_LSB]);
      OP_CHIP: region_hit = 1'b1;
      default: region_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sweep_q   <= 1'b0;
      prog_wr_q <= 1'b0;
      cnt_q     <= '0;
      ptr_q     <= '0;
    end else begin
      prog_wr_q <= start_i && (op_i == OP_PROG);
      if (start_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= (op_i == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
        sweep_q <= (op_i != OP_PROG);
        ptr_q   <= '0;
      end else begin
        if (busy_q) begin
          if (cnt_q == '0) busy_q <= 1'b0;
          else             cnt_q  <= cnt_q - 1'b1;
        end
        if (sweep_q) begin
          ptr_q <= ptr_q + 1'b1;
          if (&ptr_q) sweep_q <= 1'b0;
        end
      end
    end
  end

  assign a_addr  = sweep_q ? ptr_q : tgt_idx;
  assign a_we    = prog_wr_q | (sweep_q & region_hit);
  assign a_wdata = prog_wr_q ? (a_rdata & data_i) : {DW{1'b1}};
  assign busy_o  = busy_q;

  // R9
  sweep_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_q |-> busy_q);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i));

  // R4
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    a_we |-> busy_q);

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int DW     = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] a_addr,
  input  logic              a_we,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_rdata,
  input  logic [MEM_AW-1:0] b_addr,
  output logic [DW-1:0]     b_rdata
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 16,
  parameter int SECT_LSB  = 11,
  parameter int BLK_LSB   = 15,
  parameter int KEEP_LO   = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 1100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);

  localparam int MEM_AW = (AW - SECT_LSB) + KEEP_LO;

  logic              start;
  flash_op_e         op;
  logic [AW-1:0]     op_addr;
  logic [DW-1:0]     op_data;
  logic [MEM_AW-1:0] a_addr, b_addr;
  logic              a_we;
  logic [DW-1:0]     a_wdata, a_rdata;
  logic              unused_rd_bits;

  assign b_addr         = {rd_addr[AW-1:SECT_LSB], rd_addr[KEEP_LO-1:0]};
  assign unused_rd_bits = ^rd_addr[SECT_LSB-1:KEEP_LO];

  flash_seq_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy_i  (busy),
    .start_o (start),
    .op_o    (op),
    .addr_o  (op_addr),
    .data_o  (op_data)
  );

  flash_op_engine #(
    .AW(AW), .DW(DW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB),
    .KEEP_LO(KEEP_LO), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .op_i    (op),
    .addr_i  (op_addr),
    .data_i  (op_data),
    .a_rdata (a_rdata),
    .busy_o  (busy),
    .a_addr  (a_addr),
    .a_we    (a_we),
    .a_wdata (a_wdata)
  );

  flash_word_array #(.DW(DW), .MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .a_addr  (a_addr),
    .a_we    (a_we),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_addr  (b_addr),
    .b_rdata (rd_data)
  );

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int PROG_N  = 8;
  localparam int ERASE_N = 1100;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [18:0] wr_addr;
  logic [15:0] wr_data;
  logic [18:0] rd_addr;
  logic [15:0] rd_data;
  logic        busy;

  always #5 clk = ~clk;

  flash_cmd_seq #(.PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  // ---------------- reference model ----------------
  int    ref_mem [0:1023];
  int    step, left, cur_n, exp_rd;
  bit    gap, exp_busy, rd_chk, chk_on, done;
  int    vec, bad;
  string cur_req;

  function automatic int idx_of(int a);
    return ((a >> 11) << 2) | (a & 3);
  endfunction

  task automatic model_erase(int kind, int a);
    for (int i = 0; i < 1024; i++) begin
      if (kind == 3 || (kind == 1 && (i >> 2) == (a >> 11)) ||
          (kind == 2 && (i >> 6) == (a >> 15)))
        ref_mem[i] = 16'hFFFF;
    end
    gap = 1; cur_n = ERASE_N;
  endtask

  task automatic model_write(int a, int d);
    int d8 = d & 255;
    case (step)
      0: step = (a == 'h5555 && d8 == 'hAA) ? 1 : 0;
      1: step = (a == 'h2AAA && d8 == 'h55) ? 2 : 0;
      2: begin
        if (a == 'h5555 && d8 == 'hA0)      step = 3;
        else if (a == 'h5555 && d8 == 'h80) step = 4;
        else                                step = 0;
      end
      3: begin
        if (ref_mem[idx_of(a)] >= 0) ref_mem[idx_of(a)] = ref_mem[idx_of(a)] & d;
        gap = 1; cur_n = PROG_N; step = 0;
      end
      4: step = (a == 'h5555 && d8 == 'hAA) ? 5 : 0;
      5: step = (a == 'h2AAA && d8 == 'h55) ? 6 : 0;
      6: begin
        step = 0;
        if (d8 == 'h30)                      model_erase(1, a);
        else if (d8 == 'h50)                 model_erase(2, a);
        else if (d8 == 'h10 && a == 'h5555)  model_erase(3, a);
      end
      default: step = 0;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      step = 0; gap = 0; left = 0; exp_busy = 0; rd_chk = 0;
    end else begin
      bit g0;
      int l0, ri;
      g0 = gap; l0 = left;
      ri = idx_of(int'(rd_addr));
      rd_chk = (l0 == 0) && !g0 && (ref_mem[ri] >= 0);
      exp_rd = ref_mem[ri];
      if (g0) begin left = cur_n; gap = 0; end
      else if (left > 0) left = left - 1;
      exp_busy = (left > 0);
      if (wr_en && !g0 && l0 == 0) model_write(int'(wr_addr), int'(wr_data));
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      vec++;
      if (busy !== exp_busy) begin
        bad++;
        $display("FAIL %s busy: actual %0b expected %0b at %0t", cur_req, busy, exp_busy, $time);
      end
      if (rd_chk) begin
        vec++;
        if (rd_data !== exp_rd[15:0]) begin
          bad++;
          $display("FAIL %s rd_data @%h: actual %h expected %h", cur_req, rd_addr, rd_data, exp_rd[15:0]);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog_seq(input logic [18:0] a, input logic [15:0] d);
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h00A0); wr(a, d);
  endtask

  task automatic erase_seq(input logic [18:0] a, input logic [7:0] code);
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h0080);
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(a, {8'h00, code});
  endtask

  task automatic wait_idle();
    @(negedge clk); @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input logic [18:0] a);
    rd_addr = a;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = -1;
    vec = 0; bad = 0; chk_on = 0; done = 0; cur_n = 0;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0; chk_on = 1;
    repeat (3) @(negedge clk);

    cur_req = "R7";                       // whole-array erase at 0x05555
    erase_seq(19'h05555, 8'h10); wait_idle();
    cur_req = "R11";
    rd(19'h00000); rd(19'h7FFFF); rd(19'h12345);

    cur_req = "R3";
    prog_seq(19'h00805, 16'h1234); wait_idle(); rd(19'h00805);
    cur_req = "R4";                       // expect 0x1204
    prog_seq(19'h00805, 16'hFF0F); wait_idle(); rd(19'h00805);
    cur_req = "R11";                      // alias of 0x00805 via bits 10:2
    rd(19'h00FFD); rd(19'h00806);

    cur_req = "R2";                       // upper data byte is don't care
    wr(19'h05555, 16'h3CAA); wr(19'h02AAA, 16'hC355); wr(19'h05555, 16'h5AA0);
    wr(19'h00C02, 16'h0F0F); wait_idle(); rd(19'h00C02);

    cur_req = "R5";
    prog_seq(19'h01800, 16'h0000); wait_idle();
    prog_seq(19'h02000, 16'h1111); wait_idle();
    erase_seq(19'h01A33, 8'h30); wait_idle();
    rd(19'h01800); rd(19'h02000);

    cur_req = "R6";
    prog_seq(19'h08003, 16'h0001); wait_idle();
    prog_seq(19'h0F801, 16'h0002); wait_idle();
    prog_seq(19'h10000, 16'h0003); wait_idle();
    erase_seq(19'h09ABC, 8'h50); wait_idle();
    rd(19'h08003); rd(19'h0F801); rd(19'h10000);

    cur_req = "R7";                       // chip code away from 0x05555
    prog_seq(19'h30000, 16'h0000); wait_idle();
    erase_seq(19'h01234, 8'h10);
    repeat (4) @(negedge clk);
    rd(19'h30000);

    cur_req = "R8";
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0054);
    wr(19'h05555, 16'h00A0); wr(19'h30001, 16'h0000);
    repeat (3) @(negedge clk); rd(19'h30001);
    erase_seq(19'h30000, 8'h20);
    repeat (3) @(negedge clk); rd(19'h30000);

    cur_req = "R9";
    prog_seq(19'h20002, 16'h8001); wait_idle(); rd(19'h20002);

    cur_req = "R10";                      // back-to-back: hand-off cycle and busy
    prog_seq(19'h40000, 16'h00FF);
    prog_seq(19'h40001, 16'h0000);
    prog_seq(19'h40002, 16'h0000);
    wait_idle();
    prog_seq(19'h40003, 16'h00F0);        // first write after busy falls
    wait_idle();
    rd(19'h40000); rd(19'h40001); rd(19'h40002); rd(19'h40003);
    erase_seq(19'h40000, 8'h30);
    erase_seq(19'h05555, 8'h10);          // blocked during erase
    prog_seq(19'h00805, 16'h0000);
    wait_idle();
    rd(19'h40000); rd(19'h00805); rd(19'h01800);

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule